// File: doc/BRIEF.md
# Memory-Window Serial Flash Read Sequencer

This block places a read-only memory window in front of one or more serial flash devices. When the window is switched on, each read on the bus side becomes a complete flash read on the chosen chip select. The block sends an opcode, then a number of address bytes taken from the window offset, then a number of dummy bytes, and then clocks in the requested data bytes. Each chip select keeps its own command template, which holds the opcode, the address width, the dummy length and the lane count for the data phase.

The block is set up through a small write-only register bus. One register per chip select holds its template, and a switch register passes the flash pins between window mode and command mode. In command mode the window refuses reads with an error response and leaves the pins idle. The serial clock is one period per two system clocks (mode 0: idle low, flash samples on the rising edge). The opcode, address and dummy phases use a single output line. The data phase reads one, two or four lines. The template and the request are latched when a read is accepted.

Top module: `flash_rd_window`

## Requirements
- R1: The template for chip select n sits at register offset 0x54 + 4n. Bits [7:0] are the opcode, bits [9:8] are the address byte count minus one, bits [11:10] are the dummy byte count (0 to 3) and bits [13:12] are the data lane code. Each chip select keeps its own template.
- R2: Bit 0 of the register at offset 0x64 turns window mode on (1) or off (0). The other bits of that register are ignored. After reset the bit is 0.
- R3: A read accepted while window mode is off gets rd_ready and rd_err high in the next cycle. It causes no chip-select assertion and no serial clock edge.
- R4: The opcode, address and dummy bits go out on io line 0 only, most significant bit first, with io_oe = 4'b0001. The address is the low 8×(address bytes) bits of the offset, most significant byte first. Dummy bits are zero.
- R5: During a flash read, only the cs_n line selected by rd_cs is low.
- R6: In the data phase all io_oe bits are 0. Lane code 0 samples io line 1, code 1 samples lines [1:0] and code 3 samples lines [3:0]. The higher line carries the earlier bit. The data phase lasts 8×bytes/lanes serial clocks.
- R7: rd_len_m1+1 bytes are read. The byte at the offset lands in rd_data[7:0], the next one in [15:8], and so on. Unused upper bytes are zero.
- R8: rd_ready is high for exactly one cycle per accepted read, with rd_err low for a good read. At that point all cs_n lines are high. cs_n stays high for at least two system cycles (one serial clock period) before the next assertion.
- R9: The serial clock is low whenever no chip select is active. The output data changes only together with a falling serial clock edge.
- R10: After reset all cs_n lines are high, the serial clock is low, io_oe is 0 and rd_ready is 0.
- R11: Writes to offsets that are neither a template nor the switch register change nothing.
- R12: Lane code 2 behaves as single-line reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| rd_req | input | 1 | Read request, held until rd_ready |
| rd_cs | input | 2 | Chip select for the read |
| rd_offset | input | 32 | Window offset of the first byte |
| rd_len_m1 | input | 2 | Byte count minus one |
| rd_ready | output | 1 | One-cycle completion pulse |
| rd_err | output | 1 | Error qualifier for rd_ready |
| rd_data | output | 32 | Assembled read data |
| fl_sclk | output | 1 | Serial clock |
| fl_cs_n | output | 4 | Active-low chip selects |
| fl_io_out | output | 4 | Serial data out |
| fl_io_oe | output | 4 | Output enables per io line |
| fl_io_in | input | 4 | Serial data in |

## Verification
On every cycle, the in-line properties check the pin protocol. They cover the one-hot chip select, the idle-low clock and the output changing only on a falling clock. They also cover the chip-select gap before a new read, the quiet error response in command mode, and the switch register following its writes. Only the bench scenarios with the flash model can show that each template's opcode, address slice, dummy length, lane count and byte order reach the pins and come back in the right positions. The same holds for per-select template independence and ignored writes.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    localparam int SETUP_BASE = 'h54;
    localparam int SWITCH_OFS = 'h64;
    localparam int TMPL_W     = 14;
    localparam int CMD_SR_W   = 64;

    typedef enum logic [1:0] {
        LANE_X1 = 2'd0,
        LANE_X2 = 2'd1,
        LANE_X4 = 2'd3
    } lane_e;

    typedef struct packed {
        logic [1:0] lane_code;
        logic [1:0] dummy_bytes;
        logic [1:0] addr_bytes_m1;
        logic [7:0] opcode;
    } tmpl_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_DATA,
        S_DONE,
        S_GAP,
        S_ERR
    } seq_st_e;

    function automatic lane_e lane_decode(input logic [1:0] code);
        case (code)
            2'd1:    return LANE_X2;
            2'd3:    return LANE_X4;
            default: return LANE_X1;
        endcase
    endfunction

endpackage

// File: rtl/flash_rd_regs.sv
module flash_rd_regs
    import flash_rd_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CFG_AW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [31:0]             cfg_wdata,
    output tmpl_t [NUM_CS-1:0]      tmpl_o,
    output logic                    mm_mode_o
);

    typedef struct packed {
        tmpl_t [NUM_CS-1:0] tmpl;
        logic               mm;
    } regs_t;

    regs_t d, q;
    logic [NUM_CS-1:0] setup_hit;
    logic              switch_hit;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_hit
        assign setup_hit[g] = cfg_we && (cfg_addr == CFG_AW'(SETUP_BASE + 4 * g));
    end
    assign switch_hit = cfg_we && (cfg_addr == CFG_AW'(SWITCH_OFS));

    always_comb begin
        d = q;
        for (int i = 0; i < NUM_CS; i++) begin
            if (setup_hit[i]) d.tmpl[i] = tmpl_t'(cfg_wdata[TMPL_W-1:0]);
        end
        if (switch_hit) d.mm = cfg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tmpl_o    = q.tmpl;
    assign mm_mode_o = q.mm;

    p_switch_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_AW'(SWITCH_OFS)) |=> (mm_mode_o == $past(cfg_wdata[0])));

endmodule

// File: rtl/flash_rd_capture.sv
module flash_rd_capture
    import flash_rd_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  lane_e             lane,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [3:0]        io_in,
    output logic [ACC_W-1:0]  acc_o
);

    always_comb begin
        case (lane)
            LANE_X2: acc_o = {acc_i[ACC_W-3:0], io_in[1:0]};
            LANE_X4: acc_o = {acc_i[ACC_W-5:0], io_in[3:0]};
            default: acc_o = {acc_i[ACC_W-2:0], io_in[1]};
        endcase
    end

endmodule

// File: rtl/flash_rd_pack.sv
module flash_rd_pack #(
    parameter int MAX_BYTES = 4,
    parameter int LEN_W     = 2
) (
    input  logic [8*MAX_BYTES-1:0] acc_i,
    input  logic [LEN_W-1:0]       len_m1,
    output logic [8*MAX_BYTES-1:0] data_o
);

    always_comb begin
        data_o = '0;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (i <= int'(len_m1)) begin
                data_o[8*i +: 8] = acc_i[8*(int'(len_m1) - i) +: 8];
            end
        end
    end

endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
    import flash_rd_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int OFF_W     = 32,
    parameter int MAX_BYTES = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  tmpl_t [NUM_CS-1:0]                     tmpl,
    input  logic                                   mm_mode,
    input  logic                                   rd_req,
    input  logic [(NUM_CS > 1 ? $clog2(NUM_CS) : 1)-1:0] rd_cs,
    input  logic [OFF_W-1:0]                       rd_offset,
    input  logic [$clog2(MAX_BYTES)-1:0]           rd_len_m1,
    output logic                                   rd_ready,
    output logic                                   rd_err,
    output logic [8*MAX_BYTES-1:0]                 rd_data,
    output logic                                   sclk,
    output logic [NUM_CS-1:0]                      cs_n,
    output logic [3:0]                             io_out,
    output logic [3:0]                             io_oe,
    input  logic [3:0]                             io_in
);

    localparam int LEN_W   = $clog2(MAX_BYTES);
    localparam int DATA_W  = 8 * MAX_BYTES;
    localparam int CNT_MAX = (DATA_W > CMD_SR_W) ? DATA_W : CMD_SR_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_st_e               st;
        logic                  sclk;
        logic [NUM_CS-1:0]     csn;
        logic [CMD_SR_W-1:0]   sr;
        logic [CNT_W-1:0]      cnt;
        lane_e                 lane;
        logic [LEN_W-1:0]      len;
        logic [DATA_W-1:0]     acc;
        logic [DATA_W-1:0]     data;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: S_IDLE, sclk: 1'b0, csn: {NUM_CS{1'b1}},
                                 sr: '0, cnt: '0, lane: LANE_X1, len: '0,
                                 acc: '0, data: '0};

    seq_t d, q;

    tmpl_t             sel;
    logic [31:0]       addr32;
    logic [31:0]       addr_al;
    logic [CNT_W-1:0]  cmd_clks;
    logic [CNT_W-1:0]  data_bits;
    logic [CNT_W-1:0]  data_clks;
    logic [DATA_W-1:0] acc_nxt;
    logic [DATA_W-1:0] data_pk;

    assign sel      = tmpl[rd_cs];
    assign addr32   = 32'(rd_offset);
    assign addr_al  = addr32 << (5'd24 - {sel.addr_bytes_m1, 3'b000});
    assign cmd_clks = CNT_W'((2 + int'(sel.addr_bytes_m1) + int'(sel.dummy_bytes)) * 8);
    assign data_bits = (CNT_W'(q.len) + CNT_W'(1)) << 3;

    always_comb begin
        case (q.lane)
            LANE_X2: data_clks = data_bits >> 1;
            LANE_X4: data_clks = data_bits >> 2;
            default: data_clks = data_bits;
        endcase
    end

    flash_rd_capture #(.ACC_W(DATA_W)) i_capture (
        .lane  (q.lane),
        .acc_i (q.acc),
        .io_in (io_in),
        .acc_o (acc_nxt)
    );

    flash_rd_pack #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) i_pack (
        .acc_i  (q.acc),
        .len_m1 (q.len),
        .data_o (data_pk)
    );

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                d.sclk = 1'b0;
                d.csn  = '1;
                if (rd_req) begin
                    if (!mm_mode) begin
                        d.st = S_ERR;
                    end else begin
                        d.st   = S_CMD;
                        d.csn  = ~(NUM_CS'(1) << rd_cs);
                        d.sr   = {sel.opcode, addr_al, 24'b0};
                        d.cnt  = cmd_clks;
                        d.lane = lane_decode(sel.lane_code);
                        d.len  = rd_len_m1;
                        d.acc  = '0;
                    end
                end
            end
            S_CMD: begin
                if (!q.sclk) begin
                    d.sclk = 1'b1;
                end else begin
                    d.sclk = 1'b0;
                    d.sr   = q.sr << 1;
                    if (q.cnt == CNT_W'(1)) begin
                        d.st  = S_DATA;
                        d.cnt = data_clks;
                    end else begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end
                end
            end
            S_DATA: begin
                if (!q.sclk) begin
                    d.sclk = 1'b1;
                    d.acc  = acc_nxt;
                end else begin
                    d.sclk = 1'b0;
                    if (q.cnt == CNT_W'(1)) begin
                        d.st   = S_DONE;
                        d.csn  = '1;
                        d.data = data_pk;
                    end else begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end
                end
            end
            S_DONE:  d.st = S_GAP;
            S_GAP:   d.st = S_IDLE;
            S_ERR:   d.st = S_IDLE;
            default: d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign rd_ready = (q.st == S_DONE) || (q.st == S_ERR);
    assign rd_err   = (q.st == S_ERR);
    assign rd_data  = q.data;
    assign sclk     = q.sclk;
    assign cs_n     = q.csn;
    assign io_out   = (q.st == S_CMD) ? {3'b000, q.sr[CMD_SR_W-1]} : 4'b0000;
    assign io_oe    = (q.st == S_CMD) ? 4'b0001 : 4'b0000;

    p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && rd_req && !mm_mode) |=> (rd_ready && rd_err && (&cs_n) && !sclk));

    p_cs_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_oe_needs_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|io_oe) |-> !(&cs_n));

    p_ready_cs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (&cs_n));

    p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);

    p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && $past(&cs_n)) |-> $past(&cs_n, 2));

    p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sclk);

    p_mode0_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !$past(&cs_n) && !$stable(io_out)) |-> $fell(sclk));

endmodule

// File: rtl/flash_rd_window.sv
module flash_rd_window
    import flash_rd_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int CFG_AW    = 8,
    parameter int OFF_W     = 32,
    parameter int MAX_BYTES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [CFG_AW-1:0]          cfg_addr,
    input  logic [31:0]                cfg_wdata,
    input  logic                       rd_req,
    input  logic [(NUM_CS > 1 ? $clog2(NUM_CS) : 1)-1:0] rd_cs,
    input  logic [OFF_W-1:0]           rd_offset,
    input  logic [$clog2(MAX_BYTES)-1:0] rd_len_m1,
    output logic                       rd_ready,
    output logic                       rd_err,
    output logic [8*MAX_BYTES-1:0]     rd_data,
    output logic                       fl_sclk,
    output logic [NUM_CS-1:0]          fl_cs_n,
    output logic [3:0]                 fl_io_out,
    output logic [3:0]                 fl_io_oe,
    input  logic [3:0]                 fl_io_in
);

    tmpl_t [NUM_CS-1:0] tmpl;
    logic               mm_mode;

    flash_rd_regs #(.NUM_CS(NUM_CS), .CFG_AW(CFG_AW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .tmpl_o    (tmpl),
        .mm_mode_o (mm_mode)
    );

    flash_rd_seq #(.NUM_CS(NUM_CS), .OFF_W(OFF_W), .MAX_BYTES(MAX_BYTES)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmpl      (tmpl),
        .mm_mode   (mm_mode),
        .rd_req    (rd_req),
        .rd_cs     (rd_cs),
        .rd_offset (rd_offset),
        .rd_len_m1 (rd_len_m1),
        .rd_ready  (rd_ready),
        .rd_err    (rd_err),
        .rd_data   (rd_data),
        .sclk      (fl_sclk),
        .cs_n      (fl_cs_n),
        .io_out    (fl_io_out),
        .io_oe     (fl_io_oe),
        .io_in     (fl_io_in)
    );

endmodule

// File: tb/test_flash_rd_window.sv
module test_flash_rd_window;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rd_req = 1'b0;
    logic [1:0]  rd_cs = '0;
    logic [31:0] rd_offset = '0;
    logic [1:0]  rd_len_m1 = '0;
    logic        rd_ready, rd_err;
    logic [31:0] rd_data;
    logic        fl_sclk;
    logic [3:0]  fl_cs_n, fl_io_out, fl_io_oe;
    logic [3:0]  fl_io_in = '0;

    always #2.5 clk = ~clk;

    flash_rd_window i_flash_rd_window (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_req(rd_req), .rd_cs(rd_cs),
        .rd_offset(rd_offset), .rd_len_m1(rd_len_m1), .rd_ready(rd_ready),
        .rd_err(rd_err), .rd_data(rd_data), .fl_sclk(fl_sclk),
        .fl_cs_n(fl_cs_n), .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe),
        .fl_io_in(fl_io_in)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [31:0] a);
        return {a[3:0], a[7:4]} ^ a[15:8] ^ a[31:24] ^ 8'h5A;
    endfunction

    // behavioural flash model
    int          exp_cmd_bits = 8;
    int          exp_ab = 1;
    int          exp_db = 0;
    int          exp_w = 1;
    logic [63:0] m_sh = '0;
    int          m_rise = 0;
    int          m_total = 0;
    int          m_done = 0;
    logic [7:0]  m_op = '0;
    logic [31:0] m_addr = '0;
    logic [63:0] m_dum = '0;
    logic [3:0]  seen_cs = '1;
    int          cs_falls = 0;
    int          sclk_rises = 0;
    int          oe_bad = 0;
    int          mode0_bad = 0;
    logic        io_at_rise = 1'b0;
    wire         cs_act = ~&fl_cs_n;

    function automatic logic [31:0] amask(input int ab);
        return (ab >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * ab)) - 32'd1);
    endfunction

    function automatic logic [31:0] model_addr();
        return 32'(m_sh >> (8 * exp_db)) & amask(exp_ab);
    endfunction

    always @(posedge cs_act) begin
        m_rise  = 0;
        m_sh    = '0;
        seen_cs = fl_cs_n;
        cs_falls++;
    end

    always @(negedge cs_act) begin
        m_total = m_rise;
        m_op    = 8'(m_sh >> (exp_cmd_bits - 8));
        m_addr  = model_addr();
        m_dum   = m_sh & ((64'd1 << (8 * exp_db)) - 64'd1);
        m_done++;
    end

    always @(posedge fl_sclk) begin
        sclk_rises++;
        io_at_rise = fl_io_out[0];
        if (cs_act) begin
            if (m_rise < exp_cmd_bits) begin
                if (fl_io_oe != 4'b0001) oe_bad++;
                m_sh = {m_sh[62:0], fl_io_out[0]};
            end else if (fl_io_oe != 4'b0000) begin
                oe_bad++;
            end
            m_rise++;
        end
    end

    always @(negedge fl_sclk) begin
        if (cs_act && m_rise >= exp_cmd_bits) begin
            int p, b;
            logic [7:0] by;
            p  = (m_rise - exp_cmd_bits) * exp_w;
            b  = 7 - (p % 8);
            by = pat(model_addr() + 32'(p / 8));
            case (exp_w)
                2:       fl_io_in = {2'b00, by[b], by[b-1]};
                4:       fl_io_in = {by[b], by[b-1], by[b-2], by[b-3]};
                default: fl_io_in = {2'b00, by[b], 1'b0};
            endcase
        end
    end

    // cs_n high-time and mode-0 monitors
    int hi_run = 0;
    int min_gap = 1000;
    always @(negedge clk) begin
        if (&fl_cs_n) begin
            hi_run++;
        end else begin
            if (hi_run != 0 && hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
            if (fl_sclk && fl_io_out[0] != io_at_rise) mode0_bad++;
        end
    end

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] cs, input logic [31:0] off, input logic [1:0] lm1,
                           output logic [31:0] data, output logic err, output int lat,
                           output logic cs_hi, output logic ready_after);
        @(negedge clk);
        rd_req = 1'b1; rd_cs = cs; rd_offset = off; rd_len_m1 = lm1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rd_ready && lat < 4000);
        data  = rd_data;
        err   = rd_err;
        cs_hi = &fl_cs_n;
        rd_req = 1'b0;
        @(negedge clk);
        ready_after = rd_ready;
    endtask

    task automatic run_read(input logic [1:0] cs, input logic [13:0] st, input logic [31:0] off,
                            input logic [1:0] lm1);
        logic [31:0] data, exp_data, maddr;
        logic err, cs_hi, rdy2;
        int lat, done0;
        exp_ab = int'(st[9:8]) + 1;
        exp_db = int'(st[11:10]);
        exp_w  = (st[13:12] == 2'd1) ? 2 : (st[13:12] == 2'd3) ? 4 : 1;
        exp_cmd_bits = 8 * (1 + exp_ab + exp_db);
        maddr = off & amask(exp_ab);
        exp_data = '0;
        for (int i = 0; i <= int'(lm1); i++) exp_data[8*i +: 8] = pat(maddr + 32'(i));
        oe_bad = 0;
        mode0_bad = 0;
        done0 = m_done;
        do_read(cs, off, lm1, data, err, lat, cs_hi, rdy2);
        check(err == 1'b0, "R2 window read without error", 64'(err), 64'd0);
        check(data == exp_data, "R7 R6 R12 assembled data", 64'(data), 64'(exp_data));
        check(cs_hi == 1'b1, "R8 cs_n high at ready", 64'(cs_hi), 64'd1);
        check(rdy2 == 1'b0, "R8 single-cycle ready", 64'(rdy2), 64'd0);
        check(m_done == done0 + 1, "R5 one flash transaction", 64'(m_done), 64'(done0 + 1));
        check(m_op == st[7:0], "R1 opcode from template", 64'(m_op), 64'(st[7:0]));
        check(m_addr == maddr, "R4 address bytes", 64'(m_addr), 64'(maddr));
        check(m_dum == 64'd0, "R4 dummy bits zero", m_dum, 64'd0);
        check(m_total == exp_cmd_bits + (8 * (int'(lm1) + 1)) / exp_w, "R6 serial clock count",
              64'(m_total), 64'(exp_cmd_bits + (8 * (int'(lm1) + 1)) / exp_w));
        check(seen_cs == ~(4'b0001 << cs), "R5 selected cs_n only", 64'(seen_cs),
              64'(~(4'b0001 << cs)));
        check(oe_bad == 0, "R4 R6 output enables per phase", 64'(oe_bad), 64'd0);
        check(mode0_bad == 0, "R9 data stable while sclk high", 64'(mode0_bad), 64'd0);
    endtask

    task automatic run_err(input string tag);
        logic [31:0] data;
        logic err, cs_hi, rdy2;
        int lat, f0, s0;
        f0 = cs_falls;
        s0 = sclk_rises;
        do_read(2'd1, 32'h0000_1000, 2'd3, data, err, lat, cs_hi, rdy2);
        check(err == 1'b1, {tag, " R3 error response"}, 64'(err), 64'd1);
        check(lat == 1, {tag, " R3 error latency"}, 64'(lat), 64'd1);
        check(cs_falls == f0, {tag, " R3 no chip select"}, 64'(cs_falls), 64'(f0));
        check(sclk_rises == s0, {tag, " R3 no serial clock"}, 64'(sclk_rises), 64'(s0));
    endtask

    typedef struct packed {
        logic [1:0]  cs;
        logic [13:0] setup;
        logic [31:0] off;
        logic [1:0]  lm1;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{cs: 2'd0, setup: {2'd0, 2'd0, 2'd2, 8'h03}, off: 32'h0001_2345, lm1: 2'd3},
        '{cs: 2'd1, setup: {2'd1, 2'd1, 2'd2, 8'h3B}, off: 32'h0000_00F0, lm1: 2'd2},
        '{cs: 2'd2, setup: {2'd3, 2'd1, 2'd2, 8'h6B}, off: 32'h0000_ABCD, lm1: 2'd3},
        '{cs: 2'd3, setup: {2'd0, 2'd1, 2'd3, 8'h0B}, off: 32'h89AB_CDEF, lm1: 2'd0},
        '{cs: 2'd0, setup: {2'd3, 2'd3, 2'd0, 8'hEB}, off: 32'h0012_34FF, lm1: 2'd1},
        '{cs: 2'd1, setup: {2'd1, 2'd2, 2'd1, 8'hBB}, off: 32'h0000_FFFF, lm1: 2'd3},
        '{cs: 2'd2, setup: {2'd2, 2'd0, 2'd3, 8'h13}, off: 32'hDEAD_BEEF, lm1: 2'd3}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(fl_cs_n == 4'hF, "R10 cs_n after reset", 64'(fl_cs_n), 64'hF);
        check(fl_sclk == 1'b0, "R10 sclk after reset", 64'(fl_sclk), 64'd0);
        check(fl_io_oe == 4'h0, "R10 io_oe after reset", 64'(fl_io_oe), 64'd0);
        check(rd_ready == 1'b0, "R10 ready after reset", 64'(rd_ready), 64'd0);

        // R2 switch clear after reset -> R3 error path
        run_err("R2 reset switch");

        cfg_write(8'h64, 32'h1);
        for (int v = 0; v < NV; v++) begin
            cfg_write(8'h54 + 8'(4 * int'(VECS[v].cs)), 32'(VECS[v].setup));
            run_read(VECS[v].cs, VECS[v].setup, VECS[v].off, VECS[v].lm1);
        end

        // R11 unmapped writes, R1 per-select template kept (cs0 still holds vector 4)
        cfg_write(8'h50, 32'h0000_3FFF);
        cfg_write(8'h56, 32'h0000_3FFF);
        cfg_write(8'h68, 32'h0000_0000);
        run_read(2'd0, VECS[4].setup, 32'h0000_0077, 2'd0);
        // R1 cs3 template unaffected by later writes to other selects
        run_read(2'd3, VECS[3].setup, 32'h0102_0304, 2'd2);
        // R8 back-to-back reads, then minimum cs_n high time
        run_read(2'd2, VECS[6].setup, 32'h0000_0010, 2'd1);
        run_read(2'd2, VECS[6].setup, 32'h0000_0011, 2'd1);
        check(min_gap >= 2, "R8 cs_n high time between reads", 64'(min_gap), 64'd2);

        // R2 only bit 0 of the switch counts
        cfg_write(8'h64, 32'hFFFF_FFFE);
        run_err("R2 switch bit0 clear");
        cfg_write(8'h64, 32'h0000_0001);
        run_read(2'd1, VECS[5].setup, 32'h0000_4000, 2'd3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule